// File: doc/BRIEF.md
# Bit-Serial I2C Engine

This block is a software-serviced I2C line controller that moves exactly one bit per handshake. Software places a transmit bit, or issues a repeated-start or stop command, through a small register port. The block samples the bus at each SCL rising edge and raises status flags. Byte framing, addressing and acknowledge policy are left to software.

Any pending flag (data ready, arbitration loss, start seen, stop seen) drives the attention output. Once SCL is low, a pending flag also keeps SCL held low, so the bus waits for software. SCL and SDA are open-drain: the block outputs pull-low enables and reads the resolved bus levels back. A transmit-active gate controls two things. It decides whether the block may pull SDA low, and whether an arbitration loss can be flagged.

Register map (address on `bus_addr_i`):
- Address 0 is the data register. A write loads the transmit bit from bit 0. A read returns the last received bit in bit 0.
- Address 1 is the command register. Every bit is write-1 and has the effect listed in R9, R4, R7 and R8.
- Address 2 is the status register, read-only and without side effects. Bit 0 is data ready, bit 1 is arbitration loss, bit 2 is start seen, bit 3 is stop seen and bit 4 is transmit active.

Top module: `bit_i2c_engine`

## Requirements
- R1: After reset every flag and transmit-active are 0, attention is low, neither pull enable is asserted, and the received bit reads 0. Attention is high exactly when any of the four flags is set.
- R2: At each filtered SCL rising edge, data ready (status bit 0) is set and the filtered SDA level is captured into the received bit (data register bit 0).
- R3: Once SCL is low while any flag is pending, SCL stays pulled low until all four flags are clear. Clearing data ready alone does not release SCL while start (bit 2) or arbitration loss (bit 1) is still set.
- R4: Transmit-active (status bit 4) is set in three ways: a data register write, command bit 5 (repeated start) or command bit 6 (stop). It is cleared in three ways: a data register read, command bit 4, or an arbitration loss.
- R5: SDA is pulled low only while transmit-active is set. During SCL low it follows the inverse of the transmit bit, so a written 0 pulls SDA and a written 1 releases it.
- R6: Arbitration loss (status bit 1) is set at an SCL rising edge when transmit-active is set, SDA is released by this block and the bus SDA reads 0. In the same cycle, transmit-active is cleared.
- R7: The repeated-start command (bit 5) releases SDA during SCL low. It pulls SDA low only after SCL has been seen high for the setup interval (CLK_HZ/1e6*COND_US cycles, 200 by default).
- R8: The stop command (bit 6) pulls SDA low during SCL low. It releases SDA only after SCL has been seen high for the same interval.
- R9: Command bits 0..3 clear data ready, arbitration loss, start and stop respectively, each alone. Any data register read or write also clears data ready.
- R10: An SDA fall while SCL is high sets start (status bit 2). An SDA rise while SCL is high sets stop (status bit 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | REG_W | Register write data |
| bus_rdata_o | output | REG_W | Register read data (combinational) |
| scl_i | input | 1 | Resolved SCL bus level |
| sda_i | input | 1 | Resolved SDA bus level |
| scl_pull_o | output | 1 | Pull SCL low when 1 |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| attn_o | output | 1 | Any flag pending |

## Verification
The bit path is exercised with four patterns, each telling a different case apart:
- A received 0 driven by another device checks capture and stretching.
- A transmitted 0 checks gating by transmit-active.
- A transmitted 1 against a foreign 0 checks arbitration loss.
- A transmitted 1 against an idle line shows that no false loss is raised.

Stretching is checked with two flags pending at once, so that clearing only one of them shows SCL remains held. The repeated-start and stop sequences are checked both partway through the setup interval and after it has elapsed, which separates correct timing from an SDA edge that comes early or never.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CMD  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // flag indices, shared by status bits and clear command bits
  localparam int FLG_DRDY = 0;
  localparam int FLG_ARL  = 1;
  localparam int FLG_STA  = 2;
  localparam int FLG_STO  = 3;
  localparam int NUM_FLG  = 4;

  localparam int CMD_CLR_TXA = 4;
  localparam int CMD_RSTART  = 5;
  localparam int CMD_STOP    = 6;
  localparam int STAT_TXA    = 4;

  typedef enum logic [1:0] {
    TX_BIT    = 2'd0,
    TX_RSTART = 2'd1,
    TX_STOP   = 2'd2
  } tx_mode_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);

  logic             sync1_q, sync2_q, filt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      filt_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sync1_q <= line_i;
      sync2_q <= sync1_q;
      if (sync2_q != filt_q) begin
        if (cnt_q == CNT_W'(FILT_CYC - 1)) begin
          filt_q <= sync2_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign line_o = filt_q;
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i[i]) flag_q <= 1'b1;
      else if (clr_i[i]) flag_q <= 1'b0;
    end
    assign flags_o[i] = flag_q;
  end
endmodule

// File: rtl/i2c_tx_ctrl.sv
module i2c_tx_ctrl import i2c_bit_pkg::*; #(
  parameter int COND_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_f_i,
  input  logic sda_f_i,
  input  logic scl_rise_i,
  input  logic wr_bit_i,
  input  logic wr_val_i,
  input  logic cmd_rstart_i,
  input  logic cmd_stop_i,
  input  logic clr_txa_i,
  output logic arl_set_o,
  output logic tx_active_o,
  output logic sda_pull_o
);
  localparam int CNT_W = $clog2(COND_CYC + 1);

  tx_mode_e         mode_q;
  logic             tx_bit_q, drive_low_q, tx_active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             arl_set, txa_set;

  // loss only counts while this side has SDA released
  assign arl_set = scl_rise_i & tx_active_q & ~drive_low_q & ~sda_f_i;
  assign txa_set = wr_bit_i | cmd_rstart_i | cmd_stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= TX_BIT;
      tx_bit_q    <= 1'b1;
      drive_low_q <= 1'b0;
      cnt_q       <= '0;
    end else if (wr_bit_i) begin
      tx_bit_q <= wr_val_i;
      mode_q   <= TX_BIT;
      cnt_q    <= '0;
    end else if (cmd_rstart_i) begin
      tx_bit_q <= 1'b1;
      mode_q   <= TX_RSTART;
      cnt_q    <= '0;
    end else if (cmd_stop_i) begin
      tx_bit_q <= 1'b0;
      mode_q   <= TX_STOP;
      cnt_q    <= '0;
    end else if (!scl_f_i) begin
      drive_low_q <= ~tx_bit_q;
      cnt_q       <= '0;
    end else if (mode_q != TX_BIT) begin
      if (cnt_q == CNT_W'(COND_CYC - 1)) begin
        drive_low_q <= (mode_q == TX_RSTART);
        tx_bit_q    <= (mode_q != TX_RSTART);
        mode_q      <= TX_BIT;
        cnt_q       <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     tx_active_q <= 1'b0;
    else if (txa_set)                tx_active_q <= 1'b1;
    else if (clr_txa_i || arl_set)   tx_active_q <= 1'b0;
  end

  assign arl_set_o   = arl_set;
  assign tx_active_o = tx_active_q;
  assign sda_pull_o  = tx_active_q & drive_low_q;
endmodule

// File: rtl/bit_i2c_engine.sv
module bit_i2c_engine import i2c_bit_pkg::*; #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int COND_US  = 4,
  parameter int FILT_CYC = 3,
  parameter int REG_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_pull_o,
  output logic             sda_pull_o,
  output logic             attn_o
);
  localparam int COND_CYC = (CLK_HZ / 1_000_000) * COND_US;

  logic [1:0]       line_raw, line_f;
  logic             scl_f, sda_f;
  logic             scl_rise, start_det, stop_det;
  logic             data_wr, data_rd, cmd_wr;
  logic [NUM_FLG-1:0] flag_set, flag_clr, flags_q;
  logic             arl_set, tx_active;
  logic             rx_bit_q, scl_hold_q, pending;
  logic             unused_wdata;

  assign line_raw = {sda_i, scl_i};
  for (genvar i = 0; i < 2; i++) begin : g_line
    i2c_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(line_raw[i]),
      .line_o(line_f[i])
    );
  end
  assign scl_f = line_f[0];
  assign sda_f = line_f[1];

  i2c_cond_detect u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_f),
    .sda_i     (sda_f),
    .scl_rise_o(scl_rise),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  assign data_wr = bus_wr_i & (bus_addr_i == ADDR_DATA);
  assign data_rd = bus_rd_i & (bus_addr_i == ADDR_DATA);
  assign cmd_wr  = bus_wr_i & (bus_addr_i == ADDR_CMD);

  i2c_tx_ctrl #(.COND_CYC(COND_CYC)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_f_i     (scl_f),
    .sda_f_i     (sda_f),
    .scl_rise_i  (scl_rise),
    .wr_bit_i    (data_wr),
    .wr_val_i    (bus_wdata_i[0]),
    .cmd_rstart_i(cmd_wr & bus_wdata_i[CMD_RSTART]),
    .cmd_stop_i  (cmd_wr & bus_wdata_i[CMD_STOP]),
    .clr_txa_i   (data_rd | (cmd_wr & bus_wdata_i[CMD_CLR_TXA])),
    .arl_set_o   (arl_set),
    .tx_active_o (tx_active),
    .sda_pull_o  (sda_pull_o)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_DRDY] = scl_rise;
    flag_set[FLG_ARL]  = arl_set;
    flag_set[FLG_STA]  = start_det;
    flag_set[FLG_STO]  = stop_det;
    flag_clr           = cmd_wr ? bus_wdata_i[NUM_FLG-1:0] : '0;
    flag_clr[FLG_DRDY] = flag_clr[FLG_DRDY] | data_wr | data_rd;
  end

  i2c_flag_bank #(.N(NUM_FLG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flags_o(flags_q)
  );

  assign pending = |flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_bit_q <= 1'b0;
    else if (scl_rise) rx_bit_q <= sda_f;
  end

  // hold engages only in the low phase, never cuts a high phase short
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      scl_hold_q <= 1'b0;
    else if (!pending) scl_hold_q <= 1'b0;
    else if (!scl_f)   scl_hold_q <= 1'b1;
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_DATA: bus_rdata_o[0] = rx_bit_q;
      ADDR_STAT: begin
        bus_rdata_o[NUM_FLG-1:0] = flags_q;
        bus_rdata_o[STAT_TXA]    = tx_active;
      end
      default:   bus_rdata_o = '0;
    endcase
  end

  assign scl_pull_o   = scl_hold_q;
  assign attn_o       = pending;
  assign unused_wdata = bus_wdata_i[REG_W-1];
endmodule

// File: rtl/bit_i2c_engine_chk.sv
module bit_i2c_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_wr_i,
  input logic scl_pull_o,
  input logic sda_pull_o,
  input logic attn_o,
  input logic tx_active_i,
  input logic drdy_i,
  input logic arl_i,
  input logic scl_hi_i
);
  // R3
  stretch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(scl_pull_o) && attn_o) |-> scl_pull_o);
  // R3
  stretch_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_pull_o |-> $past(attn_o));
  // R5
  sda_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> tx_active_i);
  // R6
  arl_drops_txa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arl_i) |-> !tx_active_i);
  // R2
  drdy_on_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drdy_i) |-> scl_hi_i);
  // R4
  txa_from_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_active_i) |-> $past(bus_wr_i));
endmodule

bind bit_i2c_engine bit_i2c_engine_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_wr_i   (bus_wr_i),
  .scl_pull_o (scl_pull_o),
  .sda_pull_o (sda_pull_o),
  .attn_o     (attn_o),
  .tx_active_i(tx_active),
  .drdy_i     (flags_q[0]),
  .arl_i      (flags_q[1]),
  .scl_hi_i   (scl_f)
);

// File: tb/bit_i2c_engine_bench.sv
module bit_i2c_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       scl_pull, sda_pull, attn;
  logic       tb_scl_low = 1'b0, tb_sda_low = 1'b0;
  logic       scl_bus, sda_bus;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  assign scl_bus = ~(scl_pull | tb_scl_low);
  assign sda_bus = ~(sda_pull | tb_sda_low);

  bit_i2c_engine u_bit_i2c_engine (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bus_wr_i   (bus_wr),
    .bus_rd_i   (bus_rd),
    .bus_addr_i (bus_addr),
    .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata),
    .scl_i      (scl_bus),
    .sda_i      (sda_bus),
    .scl_pull_o (scl_pull),
    .sda_pull_o (sda_pull),
    .attn_o     (attn)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_stat(input string req, input logic [7:0] exp);
    logic [7:0] s;
    rd_reg(2'd2, s);
    chk(req, s, exp);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk_stat("R1 status after reset", 8'h00);
    chk("R1 attn after reset", attn, 1'b0);
    chk("R1 scl pull after reset", scl_pull, 1'b0);
    chk("R1 sda pull after reset", sda_pull, 1'b0);
    rd_reg(2'd0, d);
    chk("R1 rx bit after reset", d, 8'h00);
  endtask

  task automatic t_receive;
    logic [7:0] d;
    tb_scl_low = 1'b1; cyc(10);
    tb_sda_low = 1'b1; cyc(10);
    tb_scl_low = 1'b0; cyc(10);
    chk_stat("R2 drdy at scl rise", 8'h01);
    chk("R1 attn with drdy", attn, 1'b1);
    tb_scl_low = 1'b1; cyc(10);
    tb_scl_low = 1'b0; cyc(10);
    chk("R3 scl held low by drdy", scl_pull, 1'b1);
    chk("R3 bus scl low while stretched", scl_bus, 1'b0);
    tb_scl_low = 1'b1;
    rd_reg(2'd0, d);
    chk("R2 captured rx bit 0", d, 8'h00);
    cyc(3);
    chk_stat("R9 data read clears drdy", 8'h00);
    chk("R3 scl released after clear", scl_pull, 1'b0);
    chk("R1 attn low when clear", attn, 1'b0);
    tb_sda_low = 1'b0; cyc(10);
  endtask

  task automatic t_stretch_two_flags;
    tb_scl_low = 1'b0; cyc(10);
    tb_sda_low = 1'b1; cyc(10);
    chk_stat("R10 start seen with drdy", 8'h05);
    tb_scl_low = 1'b1; cyc(10);
    tb_scl_low = 1'b0; cyc(10);
    chk("R3 held with two flags", scl_pull, 1'b1);
    wr_reg(2'd1, 8'h01); cyc(3);
    chk_stat("R9 clear drdy only", 8'h04);
    chk("R3 start alone keeps scl held", scl_pull, 1'b1);
    tb_scl_low = 1'b1;
    wr_reg(2'd1, 8'h04); cyc(3);
    chk_stat("R9 clear start", 8'h00);
    chk("R3 released after last flag", scl_pull, 1'b0);
    tb_sda_low = 1'b0; cyc(10);
  endtask

  task automatic t_tx_zero;
    logic [7:0] d;
    wr_reg(2'd0, 8'h00); cyc(5);
    chk("R5 tx 0 pulls sda", sda_pull, 1'b1);
    chk_stat("R4 data write sets tx active", 8'h10);
    tb_scl_low = 1'b0; cyc(10);
    chk_stat("R6 own 0 is no loss", 8'h11);
    tb_scl_low = 1'b1; cyc(10);
    wr_reg(2'd0, 8'h00); cyc(3);
    chk_stat("R9 data write clears drdy", 8'h10);
    wr_reg(2'd1, 8'h10); cyc(3);
    chk("R5 sda released when tx inactive", sda_pull, 1'b0);
    chk_stat("R4 clear-tx-active command", 8'h00);
    wr_reg(2'd0, 8'h00); cyc(5);
    chk("R5 tx 0 pulls again", sda_pull, 1'b1);
    rd_reg(2'd0, d); cyc(3);
    chk("R4 data read drops tx active", sda_pull, 1'b0);
    chk_stat("R4 status after data read", 8'h00);
  endtask

  task automatic t_arb_loss;
    wr_reg(2'd0, 8'h01); cyc(5);
    chk("R5 tx 1 releases sda", sda_pull, 1'b0);
    tb_sda_low = 1'b1; cyc(5);
    tb_scl_low = 1'b0; cyc(10);
    chk_stat("R6 loss flagged and tx active cleared", 8'h03);
    tb_scl_low = 1'b1; cyc(10);
    wr_reg(2'd1, 8'h02); cyc(3);
    chk_stat("R9 clear loss only", 8'h01);
    chk("R3 drdy still holds scl", scl_pull, 1'b1);
    wr_reg(2'd1, 8'h01); cyc(5);
    chk("R3 scl released", scl_pull, 1'b0);
    tb_sda_low = 1'b0; cyc(10);
  endtask

  task automatic t_rstart;
    wr_reg(2'd1, 8'h20); cyc(5);
    chk("R7 sda released in low phase", sda_pull, 1'b0);
    chk_stat("R4 rstart sets tx active", 8'h10);
    tb_scl_low = 1'b0; cyc(100);
    chk("R7 sda still high before setup", sda_pull, 1'b0);
    chk_stat("R6 no loss on idle sda", 8'h11);
    cyc(160);
    chk("R7 sda pulled after setup", sda_pull, 1'b1);
    chk_stat("R10 start from own rstart", 8'h15);
    tb_scl_low = 1'b1; cyc(10);
    wr_reg(2'd1, 8'h05); cyc(3);
    chk_stat("R9 clear drdy and start", 8'h10);
  endtask

  task automatic t_stop;
    wr_reg(2'd1, 8'h40); cyc(5);
    chk("R8 sda pulled in low phase", sda_pull, 1'b1);
    tb_scl_low = 1'b0; cyc(100);
    chk("R8 sda still low before hold", sda_pull, 1'b1);
    cyc(160);
    chk("R8 sda released after hold", sda_pull, 1'b0);
    chk_stat("R10 stop flagged", 8'h19);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_receive();
    t_stretch_two_flags();
    t_tx_zero();
    t_arb_loss();
    t_rstart();
    t_stop();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule